// File: doc/BRIEF.md
# Quadrature Encoder Position and Speed Front End

This block turns the three raw lines of an incremental shaft encoder into numbers that a speed loop can use. The two phase channels and the once-per-turn marker are each brought into the clock domain and passed through a stability filter, so that short spikes never reach the decoder. The cleaned phase pair is decoded at four counts per line cycle into a signed position that rises for one direction of rotation and falls for the other. The last direction seen is reported, and a phase change that is impossible for a healthy encoder (both channels moving together) is refused and latched as an error.

A periodic sample strobe from the control loop freezes the position change since the previous strobe into a signed delta, and the same strobe loads a speed word equal to that delta times a fixed scale constant. The marker channel produces a one-clock pulse on each turn. A build parameter chooses whether that pulse also zeroes the position count, so the count can be absolute within one turn or free-running.

Top module: `qenc_speed`

## Requirements
- R1: While `rst_n` is low and after its release, before any input activity, `position`, `delta` and `speed` are zero and `dir_cw`, `index_pulse` and `seq_err` are 0.
- R2: A level change on any encoder line that lasts fewer than `FILT_LEN` clocks (default 4) after synchronisation has no effect on `position`, `index_pulse` or `seq_err`.
- R3: Each valid change of exactly one of the filtered phase lines moves `position` by exactly one count (four counts per full line cycle).
- R4: With {A,B} stepping 00, 10, 11, 01, 00 (A leading B), `position` increments by one per step and `dir_cw` reads 1.
- R5: With {A,B} stepping 00, 01, 11, 10, 00 (B leading A), `position` decrements by one per step and `dir_cw` reads 0.
- R6: Each rising edge of the filtered marker line produces `index_pulse` high for exactly one clock.
- R7: The clock after `sample_stb` is seen high, `delta` holds the two's-complement difference between `position` at that strobe and at the previous strobe (zero at reset); without a strobe `delta` keeps its value.
- R8: `speed` always equals `delta` sign-extended and multiplied by the parameter `SCALE` (default 3).
- R9: With `CLR_ON_INDEX` = 1 the marker rising edge sets `position` to zero; with `CLR_ON_INDEX` = 0 it leaves `position` unchanged.
- R10: A filtered transition in which A and B change in the same clock leaves `position` unchanged and sets `seq_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| enc_z | input | 1 | Raw once-per-turn marker |
| sample_stb | input | 1 | Sample period strobe, one clock wide |
| position | output | POS_W | Signed position count, two's complement |
| delta | output | POS_W | Signed position change over the last sample period |
| speed | output | SPD_W | Signed delta times SCALE |
| dir_cw | output | 1 | Direction of the last valid step, 1 = A leading |
| index_pulse | output | 1 | One-clock pulse per marker rising edge |
| seq_err | output | 1 | Sticky flag for a simultaneous A/B change |

## Verification
A wrong phase history inside the decoder shows at the `position` port within about seven clocks of the offending input edge (two synchroniser stages, the filter window and the count register), as a step in the wrong direction, a missing count or a spurious `seq_err`. A stale strobe snapshot cannot be seen on `position` at all; it appears only on `delta` and `speed` one clock after the next strobe, so each sample period is checked against the position moves the bench made in that period. A filter counter that fails to restart lets a short spike through, which shows as one extra count or an extra `index_pulse` a few clocks after the spike.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  // Classification of one decoder cycle from the old and new phase pair.
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_REV  = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  localparam int N_LINES = 3;  // A, B, marker
  localparam int LINE_A  = 0;
  localparam int LINE_B  = 1;
  localparam int LINE_Z  = 2;

endpackage

// File: rtl/qenc_glitch_filter.sv
module qenc_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);

  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic             sync1_q;
  logic             sync2_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             clean_q;
  logic             clean_d;

  // Stability counter: runs only while the synchronised level differs
  // from the accepted one, and restarts as soon as they agree again.
  always_comb begin
    cnt_d   = '0;
    clean_d = clean_q;
    if (sync2_q != clean_q) begin
      if (cnt_q == CNT_LAST) begin
        clean_d = sync2_q;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      cnt_q   <= '0;
      clean_q <= 1'b0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
      cnt_q   <= cnt_d;
      clean_q <= clean_d;
    end
  end

  assign clean = clean_q;

endmodule

// File: rtl/qenc_quad_decoder.sv
module qenc_quad_decoder
  import qenc_pkg::*;
#(
  parameter int POS_W        = 16,
  parameter bit CLR_ON_INDEX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a,
  input  logic             b,
  input  logic             z,
  output logic [POS_W-1:0] position,
  output logic             dir_cw,
  output logic             index_pulse,
  output logic             seq_err
);

  logic             a_q, b_q, z_q;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             dir_q, dir_d;
  logic             idx_q, idx_d;
  logic             err_q, err_d;
  step_e            step;
  logic             z_rise;

  // Step classification. In the forward order (A leading) the new A
  // always differs from the old B; in reverse it always matches it.
  always_comb begin
    step = STEP_NONE;
    if ((a ^ a_q) && (b ^ b_q)) begin
      step = STEP_BAD;
    end else if ((a ^ a_q) || (b ^ b_q)) begin
      step = (a ^ b_q) ? STEP_FWD : STEP_REV;
    end
  end

  assign z_rise = z & ~z_q;

  always_comb begin
    pos_d = pos_q;
    dir_d = dir_q;
    err_d = err_q;
    idx_d = z_rise;
    unique case (step)
      STEP_FWD: begin
        pos_d = pos_q + 1'b1;
        dir_d = 1'b1;
      end
      STEP_REV: begin
        pos_d = pos_q - 1'b1;
        dir_d = 1'b0;
      end
      STEP_BAD: err_d = 1'b1;
      default:  ;
    endcase
    // Marker clear wins over a step in the same clock.
    if (CLR_ON_INDEX && z_rise) begin
      pos_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      z_q   <= 1'b0;
      pos_q <= '0;
      dir_q <= 1'b0;
      idx_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      a_q   <= a;
      b_q   <= b;
      z_q   <= z;
      pos_q <= pos_d;
      dir_q <= dir_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  assign position    = pos_q;
  assign dir_cw      = dir_q;
  assign index_pulse = idx_q;
  assign seq_err     = err_q;

endmodule

// File: rtl/qenc_rate.sv
module qenc_rate #(
  parameter int POS_W = 16,
  parameter int SPD_W = 24,
  parameter int SCALE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [POS_W-1:0] position,
  output logic [POS_W-1:0] delta,
  output logic [SPD_W-1:0] speed
);

  logic [POS_W-1:0]        snap_q, snap_d;
  logic [POS_W-1:0]        delta_q, delta_d;
  logic [SPD_W-1:0]        speed_q, speed_d;
  logic signed [POS_W-1:0] diff;

  // Modular subtraction keeps the delta right across counter wrap.
  assign diff = $signed(position - snap_q);

  always_comb begin
    snap_d  = snap_q;
    delta_d = delta_q;
    speed_d = speed_q;
    if (sample_stb) begin
      snap_d  = position;
      delta_d = diff;
      speed_d = SPD_W'(diff) * SPD_W'(SCALE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      delta_q <= '0;
      speed_q <= '0;
    end else begin
      snap_q  <= snap_d;
      delta_q <= delta_d;
      speed_q <= speed_d;
    end
  end

  assign delta = delta_q;
  assign speed = speed_q;

endmodule

// File: rtl/qenc_speed.sv
module qenc_speed
  import qenc_pkg::*;
#(
  parameter int POS_W        = 16,
  parameter int SCALE_W      = 8,
  parameter int SCALE        = 3,
  parameter int FILT_LEN     = 4,
  parameter bit CLR_ON_INDEX = 1'b0,
  parameter int SPD_W        = POS_W + SCALE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic             sample_stb,
  output logic [POS_W-1:0] position,
  output logic [POS_W-1:0] delta,
  output logic [SPD_W-1:0] speed,
  output logic             dir_cw,
  output logic             index_pulse,
  output logic             seq_err
);

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;

  assign raw_lines[LINE_A] = enc_a;
  assign raw_lines[LINE_B] = enc_b;
  assign raw_lines[LINE_Z] = enc_z;

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    qenc_glitch_filter #(
      .FILT_LEN (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines[g]),
      .clean (clean_lines[g])
    );
  end

  qenc_quad_decoder #(
    .POS_W        (POS_W),
    .CLR_ON_INDEX (CLR_ON_INDEX)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .a           (clean_lines[LINE_A]),
    .b           (clean_lines[LINE_B]),
    .z           (clean_lines[LINE_Z]),
    .position    (position),
    .dir_cw      (dir_cw),
    .index_pulse (index_pulse),
    .seq_err     (seq_err)
  );

  qenc_rate #(
    .POS_W (POS_W),
    .SPD_W (SPD_W),
    .SCALE (SCALE)
  ) u_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .position   (position),
    .delta      (delta),
    .speed      (speed)
  );

endmodule

// File: rtl/qenc_speed_chk.sv
module qenc_speed_chk #(
  parameter int POS_W = 16,
  parameter int SPD_W = 24,
  parameter int SCALE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic [POS_W-1:0] position,
  input logic [POS_W-1:0] delta,
  input logic [SPD_W-1:0] speed,
  input logic             index_pulse,
  input logic             seq_err
);

  logic [SPD_W-1:0] speed_exp;
  assign speed_exp = SPD_W'($signed(delta)) * SPD_W'(SCALE);

  // R3, R9: position moves by one count or is cleared, never more.
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (position != $past(position)) |->
      (position == $past(position) + 1'b1 ||
       position == $past(position) - 1'b1 ||
       position == '0));

  // R6: index pulse lasts one clock.
  p_index_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    index_pulse |=> !index_pulse);

  // R7: delta only moves the clock after a strobe.
  p_delta_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(delta));

  // R8: speed register matches scaled delta register.
  p_speed_scale_r8: assert property (@(posedge clk) disable iff (!rst_n)
    speed == speed_exp);

  // R10: error flag is sticky.
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

endmodule

bind qenc_speed qenc_speed_chk #(
  .POS_W (POS_W),
  .SPD_W (SPD_W),
  .SCALE (SCALE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_stb  (sample_stb),
  .position    (position),
  .delta       (delta),
  .speed       (speed),
  .index_pulse (index_pulse),
  .seq_err     (seq_err)
);

// File: tb/qenc_speed_bench.sv
module qenc_speed_bench;

  localparam int POS_W = 16;
  localparam int SPD_W = 24;
  localparam int SCALE = 3;
  localparam int SETTLE = 12;

  logic clk;
  logic rst_n;
  logic enc_a, enc_b, enc_z, sample_stb;

  logic [POS_W-1:0] pos0, dlt0, pos1, dlt1;
  logic [SPD_W-1:0] spd0, spd1;
  logic dir0, idx0, err0, dir1, idx1, err1;

  int errors = 0;
  int checks = 0;
  int idx_cnt = 0;
  bit done = 0;

  qenc_speed u_qenc_speed (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .sample_stb(sample_stb), .position(pos0), .delta(dlt0), .speed(spd0),
    .dir_cw(dir0), .index_pulse(idx0), .seq_err(err0));

  qenc_speed #(.CLR_ON_INDEX(1'b1)) u_qenc_speed_clr (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .sample_stb(sample_stb), .position(pos1), .delta(dlt1), .speed(spd1),
    .dir_cw(dir1), .index_pulse(idx1), .seq_err(err1));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) if (idx0) idx_cnt <= idx_cnt + 1;

  // Observable selectors for the scoreboard.
  typedef enum int {S_POS0, S_DLT0, S_SPD0, S_DIR0, S_IDX0, S_ERR0,
                    S_POS1, S_IDXCNT} sel_e;
  typedef struct {
    string  req;
    sel_e   sel;
    longint exp;
  } item_t;

  item_t exp_q[$];
  event  chk_ev;

  function automatic longint observe(sel_e s);
    case (s)
      S_POS0:   return longint'($signed(pos0));
      S_DLT0:   return longint'($signed(dlt0));
      S_SPD0:   return longint'($signed(spd0));
      S_DIR0:   return longint'(dir0);
      S_IDX0:   return longint'(idx0);
      S_ERR0:   return longint'(err0);
      S_POS1:   return longint'($signed(pos1));
      default:  return longint'(idx_cnt);
    endcase
  endfunction

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        longint got;
        it  = exp_q.pop_front();
        got = observe(it.sel);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%s actual=%0d expected=%0d",
                   it.req, it.sel.name(), got, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, sel_e s, longint v);
    item_t it;
    it.req = req; it.sel = s; it.exp = v;
    exp_q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_ab(logic na, logic nb);
    enc_a = na; enc_b = nb;
    wait_n(SETTLE);
  endtask

  // A leading: 00 -> 10 -> 11 -> 01 -> 00 as {A,B}
  task automatic step_fwd();
    case ({enc_a, enc_b})
      2'b00:   set_ab(1'b1, 1'b0);
      2'b10:   set_ab(1'b1, 1'b1);
      2'b11:   set_ab(1'b0, 1'b1);
      default: set_ab(1'b0, 1'b0);
    endcase
  endtask

  task automatic step_rev();
    case ({enc_a, enc_b})
      2'b00:   set_ab(1'b0, 1'b1);
      2'b01:   set_ab(1'b1, 1'b1);
      2'b11:   set_ab(1'b1, 1'b0);
      default: set_ab(1'b0, 1'b0);
    endcase
  endtask

  task automatic strobe();
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    wait_n(2);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; enc_z = 1'b0; sample_stb = 1'b0;
    wait_n(3);
    // R1: values during reset
    expect_val("R1", S_POS0, 0);
    expect_val("R1", S_ERR0, 0);
    flush();
    rst_n = 1'b1;
    wait_n(3);
    expect_val("R1", S_POS0, 0);
    expect_val("R1", S_DLT0, 0);
    expect_val("R1", S_SPD0, 0);
    expect_val("R1", S_DIR0, 0);
    expect_val("R1", S_IDX0, 0);
    expect_val("R1", S_ERR0, 0);
    flush();

    // R3, R4: four forward steps, checked one by one
    for (int i = 1; i <= 4; i++) begin
      step_fwd();
      expect_val("R3", S_POS0, i);
      flush();
    end
    expect_val("R4", S_POS0, 4);
    expect_val("R4", S_DIR0, 1);
    flush();

    // R7, R8: first sample period
    strobe();
    expect_val("R7", S_DLT0, 4);
    expect_val("R8", S_SPD0, 4 * SCALE);
    flush();

    // R5: six reverse steps
    for (int i = 0; i < 6; i++) step_rev();
    expect_val("R5", S_POS0, -2);
    expect_val("R5", S_DIR0, 0);
    flush();

    strobe();
    expect_val("R7", S_DLT0, -6);
    expect_val("R8", S_SPD0, -6 * SCALE);
    flush();

    // R7: no strobe, delta holds while position moves
    step_fwd();
    step_rev();
    wait_n(20);
    expect_val("R7", S_DLT0, -6);
    flush();

    // R2: short spike on A (2 clocks) and on Z (3 clocks)
    enc_a = ~enc_a; wait_n(2); enc_a = ~enc_a; wait_n(SETTLE);
    enc_z = 1'b1;  wait_n(3); enc_z = 1'b0;  wait_n(SETTLE);
    expect_val("R2", S_POS0, -2);
    expect_val("R2", S_IDXCNT, 0);
    expect_val("R2", S_ERR0, 0);
    flush();

    // R6, R9: valid marker pulse
    enc_z = 1'b1; wait_n(SETTLE);
    enc_z = 1'b0; wait_n(SETTLE);
    expect_val("R6", S_IDXCNT, 1);
    expect_val("R6", S_IDX0, 0);
    expect_val("R9", S_POS0, -2);
    expect_val("R9", S_POS1, 0);
    flush();

    for (int i = 0; i < 3; i++) step_fwd();
    expect_val("R9", S_POS0, 1);
    expect_val("R9", S_POS1, 3);
    flush();

    // R10: both phases change together
    set_ab(~enc_a, ~enc_b);
    expect_val("R10", S_POS0, 1);
    expect_val("R10", S_ERR0, 1);
    flush();
    step_fwd();
    expect_val("R10", S_POS0, 2);
    expect_val("R10", S_ERR0, 1);
    flush();

    // R7: delta across the period that held the illegal step
    strobe();
    expect_val("R7", S_DLT0, 4);
    expect_val("R8", S_SPD0, 4 * SCALE);
    flush();

    wait_n(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule